// File: doc/BRIEF.md
# Floating-Point Issue and Hazard Scoreboard

This block sits in front of a floating-point datapath and runs in the FPU clock domain. Each cycle it looks at the one instruction offered to it and decides whether that instruction may start. For each of the 32 floating-point registers it keeps a count of the cycles left before that register's pending result can be read. It looks up a fixed result latency for each operation class. It keeps the divider and the square-root unit, neither of which is pipelined, to one operation each. Loads and stores are limited to one outstanding each. It also keeps a minimum gap of two cycles between accepted instructions.

Instructions arrive on a valid/ready interface. The sender raises `ins_valid` and holds every instruction field steady until a cycle in which `ins_ready` is also high. That cycle is the acceptance cycle. `ins_ready` is computed from the presented fields and the internal state. It is meaningful whether or not `ins_valid` is high, and it changes nothing unless both are high. Back-pressure has no limit: the sender waits for as long as the hazard persists.

A fused multiply-add reads its addend later than its multiplicands. A chain of multiply-accumulates in which each addend is the previous result can therefore start every 6 cycles, not every 10. The load-return and store-done strobes come from the memory side and end the outstanding load and store.

Top module: `fpu_issue_sb`

## Requirements
- R1: The class code on `ins_class` sets the result latency L: 0 add/sub 6, 1 multiply 5, 2 divide 17, 3 square root 17, 4 convert 6, 5 fused multiply-add 10, 6 move/abs/negate 2. If an instruction reads a register written by one of these, and nothing else blocks it, it is accepted exactly L cycles after the producer.
- R2: Strict source operands, by class: add, multiply, divide and compare read A and B. Square root, convert, move and store read A. Fused multiply-add reads A and B as multiplicands. Load reads no source. A field the class does not read has no effect on acceptance. `reg_ready[i]` is low from the producer's acceptance until its result can be read.
- R3: Two accepted instructions are never in adjacent cycles. Independent instructions offered back to back are accepted two cycles apart.
- R4: At most one divide and at most one square root are in flight. A second divide is accepted no earlier than 17 cycles after the first, and the same holds for square root. Divide and square root do not block each other.
- R5: For a fused multiply-add, the addend C may still have up to 4 cycles of its pending result left at acceptance. The multiplicands A and B must be fully ready.
- R6: A load (class 8) leaves its destination pending until a cycle with `ld_return` high. A new load is not accepted while one is outstanding. If `ld_return` and a new load arrive in the same cycle, that load is accepted no earlier than the next cycle.
- R7: A store (class 9) waits for source A to be ready. After a store is accepted, no further store is accepted until a cycle with `st_done` high.
- R8: An instruction that writes register D with latency L is held while D's remaining pending count is L or more, or while D is the target of an outstanding load.
- R9: A compare (class 7) writes no floating-point register. Its destination field is ignored, and no register becomes pending.
- R10: Class codes 10 to 15 are never accepted.
- R11: Synchronous active-high `rst` clears every pending count, the unit and load/store busy state and the issue gap. After reset, all registers are ready and the first instruction is accepted at once.
- R12: With `ins_valid` low, no state changes, whatever `ins_ready` shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | FPU clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | An instruction is offered |
| ins_ready | output | 1 | The offered instruction may start this cycle |
| ins_class | input | 4 | Operation class code |
| ins_dst | input | 5 | Destination register index |
| ins_src_a | input | 5 | First source register index |
| ins_src_b | input | 5 | Second source register index |
| ins_src_c | input | 5 | Addend register index for fused multiply-add |
| ld_return | input | 1 | Data for the outstanding load has arrived |
| st_done | input | 1 | The outstanding store has completed |
| reg_ready | output | 32 | One bit per register, high when its value can be read |

## Verification
Two functions can fall in the same cycle: the release of the outstanding load and the acceptance test for the next load. The bench provokes this by raising `ld_return` in the same cycle as it offers a second load. It then judges three things: `ins_ready` stays low in that cycle, the returned register reads as ready right after the edge, and the second load is accepted on the following edge. A second overlap is between a fused multiply-add's late addend check and the issue gap. A chained accumulate is offered in the cycle its addend reaches the slack limit, and the bench checks that it starts exactly 6 cycles after its predecessor.

// File: rtl/fpu_sb_pkg.sv
package fpu_sb_pkg;

  typedef enum logic [3:0] {
    OPC_ADD   = 4'd0,
    OPC_MUL   = 4'd1,
    OPC_DIV   = 4'd2,
    OPC_SQRT  = 4'd3,
    OPC_CVT   = 4'd4,
    OPC_FMA   = 4'd5,
    OPC_MOV   = 4'd6,
    OPC_CMP   = 4'd7,
    OPC_LOAD  = 4'd8,
    OPC_STORE = 4'd9
  } op_class_e;

  // result latencies in FPU cycles, register read and write included
  localparam int LAT_ADD  = 6;
  localparam int LAT_MUL  = 5;
  localparam int LAT_DIV  = 17;
  localparam int LAT_SQRT = 17;
  localparam int LAT_CVT  = 6;
  localparam int LAT_FMA  = 10;
  localparam int LAT_MOV  = 2;
  localparam int LAT_CMP  = 3;
  localparam int LAT_MAX  = 17;
  localparam int LAT_W    = $clog2(LAT_MAX + 1);

  localparam int ISSUE_SPACING    = 2;
  // the addend is consumed this many cycles after the multiplicands
  localparam int FMA_ADDEND_SLACK = LAT_FMA - LAT_ADD;

  typedef struct packed {
    logic             legal;
    logic             use_a;
    logic             use_b;
    logic             use_late_c;
    logic             writes_fpr;
    logic [LAT_W-1:0] lat;
    logic             on_div;
    logic             on_sqrt;
    logic             is_load;
    logic             is_store;
  } op_info_t;

endpackage

// File: rtl/fpu_sb_decode.sv
module fpu_sb_decode
  import fpu_sb_pkg::*;
(
  input  logic [3:0] cls_i,
  output op_info_t   info_o
);

  always_comb begin
    info_o = '0;
    case (cls_i)
      OPC_ADD: begin
        info_o.legal = 1'b1; info_o.use_a = 1'b1; info_o.use_b = 1'b1;
        info_o.writes_fpr = 1'b1; info_o.lat = LAT_W'(LAT_ADD);
      end
      OPC_MUL: begin
        info_o.legal = 1'b1; info_o.use_a = 1'b1; info_o.use_b = 1'b1;
        info_o.writes_fpr = 1'b1; info_o.lat = LAT_W'(LAT_MUL);
      end
      OPC_DIV: begin
        info_o.legal = 1'b1; info_o.use_a = 1'b1; info_o.use_b = 1'b1;
        info_o.writes_fpr = 1'b1; info_o.lat = LAT_W'(LAT_DIV);
        info_o.on_div = 1'b1;
      end
      OPC_SQRT: begin
        info_o.legal = 1'b1; info_o.use_a = 1'b1;
        info_o.writes_fpr = 1'b1; info_o.lat = LAT_W'(LAT_SQRT);
        info_o.on_sqrt = 1'b1;
      end
      OPC_CVT: begin
        info_o.legal = 1'b1; info_o.use_a = 1'b1;
        info_o.writes_fpr = 1'b1; info_o.lat = LAT_W'(LAT_CVT);
      end
      OPC_FMA: begin
        info_o.legal = 1'b1; info_o.use_a = 1'b1; info_o.use_b = 1'b1;
        info_o.use_late_c = 1'b1;
        info_o.writes_fpr = 1'b1; info_o.lat = LAT_W'(LAT_FMA);
      end
      OPC_MOV: begin
        info_o.legal = 1'b1; info_o.use_a = 1'b1;
        info_o.writes_fpr = 1'b1; info_o.lat = LAT_W'(LAT_MOV);
      end
      OPC_CMP: begin
        // result goes to a condition field, not to a register
        info_o.legal = 1'b1; info_o.use_a = 1'b1; info_o.use_b = 1'b1;
        info_o.lat = LAT_W'(LAT_CMP);
      end
      OPC_LOAD: begin
        info_o.legal = 1'b1; info_o.writes_fpr = 1'b1; info_o.is_load = 1'b1;
      end
      OPC_STORE: begin
        info_o.legal = 1'b1; info_o.use_a = 1'b1; info_o.is_store = 1'b1;
      end
      default: info_o = '0;
    endcase
  end

endmodule

// File: rtl/fpu_sb_cntbank.sv
module fpu_sb_cntbank #(
  parameter  int NUM_REGS = 32,
  parameter  int CNT_W    = 5,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               set_en,
  input  logic [IDX_W-1:0]                   set_idx,
  input  logic [CNT_W-1:0]                   set_val,
  output logic [NUM_REGS-1:0][CNT_W-1:0]     cnt_o,
  output logic [NUM_REGS-1:0]                idle_o
);

  // one countdown per register: cycles left until its result is readable
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [CNT_W-1:0] left_q;
    logic             hit;

    assign hit = set_en && (set_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst)                left_q <= '0;
      else if (hit)           left_q <= set_val;
      else if (left_q != '0)  left_q <= left_q - CNT_W'(1);
    end

    assign cnt_o[g]  = left_q;
    assign idle_o[g] = (left_q == '0);
  end

  // a new result never lands before an older one to the same register
  AST_WAW_ORDER: assert property (@(posedge clk) disable iff (rst)
    set_en |-> (cnt_o[set_idx] <= set_val)) else $error("write order broken"); // R8

endmodule

// File: rtl/fpu_sb_units.sv
module fpu_sb_units #(
  parameter  int ISSUE_GAP = 2,
  parameter  int DIV_LAT   = 17,
  parameter  int SQRT_LAT  = 17,
  parameter  int IDX_W     = 5,
  localparam int GAP_W     = $clog2(ISSUE_GAP + 1),
  localparam int UMAX      = (DIV_LAT > SQRT_LAT) ? DIV_LAT : SQRT_LAT,
  localparam int DSQ_W     = $clog2(UMAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_i,
  input  logic             div_start_i,
  input  logic             sqrt_start_i,
  input  logic             ld_start_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic             ld_return_i,
  input  logic             st_start_i,
  input  logic             st_done_i,
  output logic             gap_ok_o,
  output logic             div_free_o,
  output logic             sqrt_free_o,
  output logic             st_free_o,
  output logic             ld_busy_o,
  output logic [IDX_W-1:0] ld_idx_o
);

  // issue spacing counter
  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst)              gap_q <= '0;
    else if (issue_i)     gap_q <= GAP_W'(ISSUE_GAP - 1);
    else if (gap_q != '0) gap_q <= gap_q - GAP_W'(1);
  end
  assign gap_ok_o = (gap_q == '0);

  // non-pipelined units: index 0 divider, index 1 square root
  logic [1:0] start_v;
  logic [1:0] free_v;
  assign start_v = {sqrt_start_i, div_start_i};

  for (genvar u = 0; u < 2; u++) begin : g_unit
    localparam int ULAT = (u == 0) ? DIV_LAT : SQRT_LAT;
    logic [DSQ_W-1:0] left_q;

    always_ff @(posedge clk) begin
      if (rst)                left_q <= '0;
      else if (start_v[u])    left_q <= DSQ_W'(ULAT - 1);
      else if (left_q != '0)  left_q <= left_q - DSQ_W'(1);
    end
    assign free_v[u] = (left_q == '0);

    AST_UNIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
      start_v[u] |-> (left_q == '0)) else $error("unit started twice"); // R4
  end

  assign div_free_o  = free_v[0];
  assign sqrt_free_o = free_v[1];

  // single outstanding load
  logic             ld_busy_q;
  logic [IDX_W-1:0] ld_idx_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      ld_busy_q <= 1'b0;
      ld_idx_q  <= '0;
    end else if (ld_start_i) begin
      ld_busy_q <= 1'b1;
      ld_idx_q  <= ld_idx_i;
    end else if (ld_return_i) begin
      ld_busy_q <= 1'b0;
    end
  end
  assign ld_busy_o = ld_busy_q;
  assign ld_idx_o  = ld_idx_q;

  // single outstanding store
  logic st_busy_q;
  always_ff @(posedge clk) begin
    if (rst)             st_busy_q <= 1'b0;
    else if (st_start_i) st_busy_q <= 1'b1;
    else if (st_done_i)  st_busy_q <= 1'b0;
  end
  assign st_free_o = !st_busy_q;

  AST_LD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ld_start_i |-> !ld_busy_q) else $error("second load started"); // R6
  AST_ST_SINGLE: assert property (@(posedge clk) disable iff (rst)
    st_start_i |-> !st_busy_q) else $error("second store started"); // R7

endmodule

// File: rtl/fpu_issue_sb.sv
module fpu_issue_sb
  import fpu_sb_pkg::*;
#(
  parameter  int NUM_REGS  = 32,
  parameter  int ISSUE_GAP = ISSUE_SPACING,
  localparam int IDX_W     = $clog2(NUM_REGS),
  localparam int CNT_W     = $clog2(LAT_MAX)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ins_valid,
  output logic                ins_ready,
  input  logic [3:0]          ins_class,
  input  logic [IDX_W-1:0]    ins_dst,
  input  logic [IDX_W-1:0]    ins_src_a,
  input  logic [IDX_W-1:0]    ins_src_b,
  input  logic [IDX_W-1:0]    ins_src_c,
  input  logic                ld_return,
  input  logic                st_done,
  output logic [NUM_REGS-1:0] reg_ready
);

  op_info_t info;
  fpu_sb_decode u_dec (.cls_i(ins_class), .info_o(info));

  logic                           accept;
  logic                           set_en;
  logic [CNT_W-1:0]               set_val;
  logic [NUM_REGS-1:0][CNT_W-1:0] cnt;
  logic [NUM_REGS-1:0]            idle;

  fpu_sb_cntbank #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst(rst), .set_en(set_en), .set_idx(ins_dst),
    .set_val(set_val), .cnt_o(cnt), .idle_o(idle)
  );

  logic             gap_ok, div_free, sqrt_free, st_free, ld_busy;
  logic [IDX_W-1:0] ld_idx;

  fpu_sb_units #(.ISSUE_GAP(ISSUE_GAP), .DIV_LAT(LAT_DIV), .SQRT_LAT(LAT_SQRT),
                 .IDX_W(IDX_W)) u_units (
    .clk(clk), .rst(rst), .issue_i(accept),
    .div_start_i(accept && info.on_div),
    .sqrt_start_i(accept && info.on_sqrt),
    .ld_start_i(accept && info.is_load), .ld_idx_i(ins_dst),
    .ld_return_i(ld_return),
    .st_start_i(accept && info.is_store), .st_done_i(st_done),
    .gap_ok_o(gap_ok), .div_free_o(div_free), .sqrt_free_o(sqrt_free),
    .st_free_o(st_free), .ld_busy_o(ld_busy), .ld_idx_o(ld_idx)
  );

  // register targeted by the outstanding load
  logic [NUM_REGS-1:0] ld_mask;
  always_comb begin
    ld_mask = '0;
    if (ld_busy) ld_mask[ld_idx] = 1'b1;
  end

  assign reg_ready = idle & ~ld_mask;

  // operand, destination and unit checks
  logic             a_ok, b_ok, c_ok, waw_ok, unit_ok;
  logic [CNT_W-1:0] dst_left;

  assign dst_left = cnt[ins_dst];
  assign a_ok = !info.use_a || reg_ready[ins_src_a];
  assign b_ok = !info.use_b || reg_ready[ins_src_b];
  assign c_ok = !info.use_late_c ||
                ((cnt[ins_src_c] <= CNT_W'(FMA_ADDEND_SLACK)) && !ld_mask[ins_src_c]);

  always_comb begin
    if (!info.writes_fpr)  waw_ok = 1'b1;
    else if (info.is_load) waw_ok = (dst_left == '0) && !ld_mask[ins_dst];
    else                   waw_ok = (32'(dst_left) < 32'(info.lat)) && !ld_mask[ins_dst];
  end

  assign unit_ok = !(info.on_div   && !div_free)  &&
                   !(info.on_sqrt  && !sqrt_free) &&
                   !(info.is_load  && ld_busy)    &&
                   !(info.is_store && !st_free);

  assign ins_ready = info.legal && gap_ok && a_ok && b_ok && c_ok && waw_ok && unit_ok;
  assign accept    = ins_valid && ins_ready;

  assign set_en  = accept && info.writes_fpr && !info.is_load;
  assign set_val = CNT_W'(info.lat - LAT_W'(1));

  if (ISSUE_GAP > 1) begin : g_gap_chk
    AST_ISSUE_GAP: assert property (@(posedge clk) disable iff (rst)
      accept |=> !accept) else $error("adjacent issues"); // R3
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ins_valid && !ld_return && (reg_ready == '1) |=> (reg_ready == '1)) else $error("state moved while idle"); // R12

endmodule

// File: tb/fpu_issue_sb_tb_top.sv
module fpu_issue_sb_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [3:0]  ins_class = '0;
  logic [4:0]  ins_dst = '0, ins_src_a = '0, ins_src_b = '0, ins_src_c = '0;
  logic        ld_return = 1'b0;
  logic        st_done = 1'b0;
  logic [31:0] reg_ready;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  fpu_issue_sb dut_i (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_class(ins_class), .ins_dst(ins_dst), .ins_src_a(ins_src_a),
    .ins_src_b(ins_src_b), .ins_src_c(ins_src_c), .ld_return(ld_return),
    .st_done(st_done), .reg_ready(reg_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_lat(input int cls);
    case (cls)
      0: return 6;  1: return 5;  2: return 17; 3: return 17;
      4: return 6;  5: return 10; 6: return 2;  default: return 0;
    endcase
  endfunction

  // 0 = slot not read, 1 = strict source, 2 = late addend
  function automatic int slot_use(input int cls, input int slot);
    case (cls)
      0, 1, 2, 7: return (slot < 2) ? 1 : 0;
      3, 4, 6, 9: return (slot == 0) ? 1 : 0;
      5:          return (slot < 2) ? 1 : 2;
      default:    return 0;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ins_valid = 1'b0; ld_return = 1'b0; st_done = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic put(input int cls, input int dst, input int a, input int b, input int c);
    ins_class = 4'(cls); ins_dst = 5'(dst);
    ins_src_a = 5'(a); ins_src_b = 5'(b); ins_src_c = 5'(c);
  endtask

  // offer from the next negedge on; waits = cycles stalled before acceptance
  task automatic issue(input int cls, input int dst, input int a, input int b,
                       input int c, output int waits);
    @(negedge clk);
    put(cls, dst, a, b, c);
    ins_valid = 1'b1;
    waits = 0;
    #1;
    while (!ins_ready && waits < 500) begin
      @(negedge clk);
      waits++;
      #1;
    end
    @(posedge clk);
    #1 ins_valid = 1'b0;
  endtask

  int w;

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    do_reset();

    // R11 reset state
    @(negedge clk); put(6, 1, 0, 0, 0); #1;
    chk(reg_ready == '1, "R11 regs ready after reset", int'(reg_ready == '1), 1);
    chk(ins_ready == 1'b1, "R11 ready after reset", int'(ins_ready), 1);

    // R12 valid low changes nothing
    @(negedge clk); put(1, 14, 0, 0, 0); ins_valid = 1'b0;
    @(posedge clk); #1;
    chk(reg_ready[14] == 1'b1, "R12 idle offer ignored", int'(reg_ready[14]), 1);

    // R1 latency sweep for every register-writing class
    for (int cls = 0; cls < 7; cls++) begin
      do_reset();
      issue(cls, 12, 0, 0, 0, w);
      chk(reg_ready[12] == 1'b0, "R2 dest pending", int'(reg_ready[12]), 0);
      issue(6, 13, 12, 0, 0, w);
      chk(w == exp_lat(cls) - 1, "R1 dependent start", w, exp_lat(cls) - 1);
    end

    // R2 / R5 source usage sweep: register 9 pending (multiply, 4 left)
    for (int cls = 0; cls < 10; cls++) begin
      for (int slot = 0; slot < 3; slot++) begin
        int e;
        do_reset();
        issue(1, 9, 0, 0, 0, w);
        issue(cls, 10, (slot == 0) ? 9 : 0, (slot == 1) ? 9 : 0, (slot == 2) ? 9 : 0, w);
        e = (slot_use(cls, slot) == 1) ? 4 : 1;
        chk(w == e, (slot_use(cls, slot) == 2) ? "R5 late addend" : "R2 operand usage", w, e);
      end
    end

    // R3 spacing
    do_reset();
    issue(6, 1, 0, 0, 0, w);
    issue(6, 2, 0, 0, 0, w);
    chk(w == 1, "R3 back-to-back spacing", w, 1);

    // R4 divide and square root occupancy
    do_reset();
    issue(2, 1, 0, 0, 0, w);
    issue(2, 2, 0, 0, 0, w);
    chk(w == 16, "R4 second divide", w, 16);
    do_reset();
    issue(2, 1, 0, 0, 0, w);
    issue(3, 2, 0, 0, 0, w);
    chk(w == 1, "R4 sqrt beside divide", w, 1);
    issue(3, 3, 0, 0, 0, w);
    chk(w == 16, "R4 second sqrt", w, 16);

    // R5 accumulate chain and multiplicand dependency
    do_reset();
    issue(5, 3, 0, 0, 0, w);
    issue(5, 4, 0, 0, 3, w);
    chk(w == 5, "R5 chain every 6", w, 5);
    issue(5, 5, 4, 0, 0, w);
    chk(w == 9, "R5 multiplicand strict", w, 9);

    // R8 write after write
    do_reset();
    issue(1, 5, 0, 0, 0, w);
    issue(6, 5, 0, 0, 0, w);
    chk(w == 3, "R8 waw hold", w, 3);

    // R7 store source wait and single store
    do_reset();
    issue(1, 7, 0, 0, 0, w);
    issue(9, 0, 7, 0, 0, w);
    chk(w == 4, "R7 store source", w, 4);
    @(negedge clk); put(9, 0, 0, 0, 0); ins_valid = 1'b1;
    repeat (3) begin
      #1 chk(ins_ready == 1'b0, "R7 store busy", int'(ins_ready), 0);
      @(negedge clk);
    end
    st_done = 1'b1;
    @(posedge clk); #1 st_done = 1'b0;
    @(negedge clk); #1;
    chk(ins_ready == 1'b1, "R7 store after done", int'(ins_ready), 1);
    @(posedge clk); #1 ins_valid = 1'b0;

    // R9 compare leaves registers alone
    do_reset();
    issue(7, 8, 0, 0, 0, w);
    chk(reg_ready == '1, "R9 compare no pending", int'(reg_ready == '1), 1);
    issue(6, 9, 8, 0, 0, w);
    chk(w == 1, "R9 reader of cmp dst", w, 1);

    // R6 load pending, collision of return with a new load
    do_reset();
    issue(8, 6, 0, 0, 0, w);
    chk(reg_ready[6] == 1'b0, "R6 load dest pending", int'(reg_ready[6]), 0);
    repeat (2) @(negedge clk);
    @(negedge clk);
    put(8, 11, 0, 0, 0); ins_valid = 1'b1; ld_return = 1'b1;
    #1 chk(ins_ready == 1'b0, "R6 load blocked in return cycle", int'(ins_ready), 0);
    @(posedge clk); #1 ld_return = 1'b0;
    chk(reg_ready[6] == 1'b1, "R6 returned reg ready", int'(reg_ready[6]), 1);
    @(negedge clk); #1;
    chk(ins_ready == 1'b1, "R6 next load ready", int'(ins_ready), 1);
    @(posedge clk); #1 ins_valid = 1'b0;
    chk(reg_ready[11] == 1'b0, "R6 second load pending", int'(reg_ready[11]), 0);
    issue(6, 13, 11, 0, 0, w);
    chk(w == 500, "R6 reader waits for return", w, 500);

    // R10 undefined codes
    do_reset();
    for (int code = 10; code < 16; code++) begin
      @(negedge clk); put(code, 1, 0, 0, 0); #1;
      chk(ins_ready == 1'b0, "R10 undefined class", int'(ins_ready), 0);
    end

    // R11 reset mid-flight
    do_reset();
    issue(2, 1, 0, 0, 0, w);
    do_reset();
    @(negedge clk); #1;
    chk(reg_ready == '1, "R11 reset clears pending", int'(reg_ready == '1), 1);
    issue(2, 2, 0, 0, 0, w);
    chk(w == 0, "R11 divide free after reset", w, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule